// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Acknowledge

This block sorts out which of several peripheral modules gets served when they all share one interrupt request line to a processor. Each module owns a cell in a serial chain, and each cell holds a fixed handler vector. A request pulse is latched in its cell. Every latched request that is not masked drives the shared interrupt line. When the processor answers with an acknowledge pulse, the pulse enters at the cell nearest the processor (index 0). Each cell without an eligible request passes it on unchanged. The first cell with an eligible request stops it and puts its vector on the shared vector bus in that same cycle. The processor uses that vector to select the handler.

A nesting layer keeps one in-service bit per cell. A granted cell becomes in service. While a level is in service, requests at that level and at every lower-priority level are held back. A higher-priority request can still raise the line and preempt the running handler. An end-of-interrupt pulse retires the highest-priority level that is in service.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `int_o` is 0, `vec_valid_o` is 0 and `vec_o` equals the idle value DEFAULT_VEC (0xFF by default).
- R2: A single-cycle high on `req_i[k]` is latched in cell k. If not masked, `int_o` is 1 from the next cycle and stays 1 until that cell is granted.
- R3: `int_o` is the OR of every latched request that is not masked. It is 1 in every cycle in which a vector is supplied.
- R4: While `ack_i` is high, the lowest-index cell with an unmasked latched request wins. In that same cycle `vec_o` equals VEC_BASE + k (0x20 + k by default) and `vec_valid_o` is 1.
- R5: At most one cell drives the vector bus. When no cell is granted, `vec_o` is DEFAULT_VEC and `vec_valid_o` is 0.
- R6: A winning cell's latch is cleared at the end of the acknowledge cycle, even if its `req_i` bit is high in that cycle. Other latched requests are kept.
- R7: A grant marks that cell in service. Requests at an index equal to or greater than the lowest in-service index are masked: they do not raise `int_o`, and they pass the acknowledge on.
- R8: A request at an index lower than every in-service index raises `int_o` and is granted on acknowledge, nesting above the running level.
- R9: A one-cycle `eoi_i` clears the lowest-index in-service bit. With nothing in service it has no effect.
- R10: An acknowledge with no unmasked latched request changes no state and returns DEFAULT_VEC with `vec_valid_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_CELLS | Request pulses, one per cell; bit 0 has the highest priority |
| ack_i | input | 1 | Acknowledge pulse from the processor, one cycle per vector fetch |
| eoi_i | input | 1 | End-of-interrupt pulse |
| int_o | output | 1 | Shared interrupt request to the processor |
| vec_o | output | VEC_W | Vector bus, DEFAULT_VEC when no cell drives it |
| vec_valid_o | output | 1 | High in a cycle in which a cell supplies its vector |

## Verification
The acknowledge is tried in four situations:
- with nothing latched, which separates a correct pass-through from a spurious grant;
- with several requests latched at once, which shows whether the winner comes from chain position rather than arrival order;
- while a level is in service, where masked requests must let the acknowledge fall through to the idle vector while a higher-priority request still gets in;
- in the same cycle as a repeated request from the winning cell, which exposes whether clearing on grant takes precedence over setting.

End-of-interrupt pulses are interleaved between grants, so each retire is seen through which request reappears on the interrupt line. A final pulse with nothing in service must leave the line low.

// File: rtl/irq_chain_pkg.sv
// Package irq_chain_pkg
// Shared constants and helpers for the interrupt chain.
// Assumes vectors are VEC_BASE + index and do not collide with the idle value.
package irq_chain_pkg;
    localparam int unsigned DEF_VEC_W = 8;

    // Vector assigned to the cell at position idx.
    function automatic logic [DEF_VEC_W-1:0] cell_vector(input logic [DEF_VEC_W-1:0] base,
                                                         input int unsigned idx);
        return base + DEF_VEC_W'(idx);
    endfunction
endpackage

// File: rtl/irq_chain_cell.sv
// Module irq_chain_cell
// One link of the acknowledge chain. It latches its request, claims the incoming
// acknowledge when its request is eligible, and otherwise passes the acknowledge on.
// Assumes elig_i comes from the in-service layer and is registered state only.
module irq_chain_cell #(
    parameter int unsigned      VEC_W  = 8,
    parameter logic [VEC_W-1:0] VECTOR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             ack_in,
    input  logic             elig_i,
    output logic             ack_out,
    output logic             claim_o,
    output logic             grant_o,
    output logic [VEC_W-1:0] vec_o
);
    logic pend_q;

    // Request latch: set by a request, cleared on grant (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q | req_i) & ~grant_o;
    end

    // Claim, grant, pass-through and vector drive.
    always_comb begin
        claim_o = pend_q & elig_i;
        grant_o = ack_in & claim_o;
        ack_out = ack_in & ~claim_o;
        vec_o   = grant_o ? VECTOR : '0;
    end
endmodule

// File: rtl/irq_isr_stack.sv
// Module irq_isr_stack
// In-service bits for nested handling. A grant sets its bit; an end-of-interrupt
// clears the lowest-index set bit. Produces a per-cell eligibility mask that is
// high only above every in-service level. Assumes index 0 is highest priority.
module irq_isr_stack #(
    parameter int unsigned N_CELLS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] grant_i,
    input  logic               eoi_i,
    output logic [N_CELLS-1:0] elig_o,
    output logic [N_CELLS-1:0] isr_o
);
    logic [N_CELLS-1:0] isr_q;
    logic [N_CELLS-1:0] top_bit;

    // Isolate the highest-priority in-service bit.
    always_comb top_bit = isr_q & ~(isr_q - N_CELLS'(1));

    // In-service update: retire the top level, then record a new grant.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~(eoi_i ? top_bit : '0)) | grant_i;
    end

    assign isr_o = isr_q;

    // Eligibility chain: a cell is eligible when it and all above are idle.
    assign elig_o[0] = ~isr_q[0];
    for (genvar i = 1; i < N_CELLS; i++) begin : g_elig
        assign elig_o[i] = elig_o[i-1] & ~isr_q[i];
    end

    AST_EOI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && (|isr_q) && !(|grant_i)) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R9
    AST_EOI_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(|isr_q) && !(|grant_i)) |=> (isr_q == '0)); // R9
    AST_GRANT_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_i) && !eoi_i) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1)); // R7
endmodule

// File: rtl/irq_chain_ctrl.sv
// Module irq_chain_ctrl
// Daisy-chained vectored interrupt controller. Cells share one interrupt line;
// the acknowledge enters at cell 0 and the first eligible requester returns its
// vector in the same cycle. Nesting masks equal and lower priorities.
// Assumes ack_i and eoi_i are single-cycle pulses synchronous to clk.
module irq_chain_ctrl
    import irq_chain_pkg::*;
#(
    parameter int unsigned          N_CELLS     = 4,
    parameter int unsigned          VEC_W       = DEF_VEC_W,
    parameter logic [VEC_W-1:0]     VEC_BASE    = 8'h20,
    parameter logic [VEC_W-1:0]     DEFAULT_VEC = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] req_i,
    input  logic               ack_i,
    input  logic               eoi_i,
    output logic               int_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               vec_valid_o
);
    localparam int unsigned LINKS = N_CELLS + 1;

    logic [LINKS-1:0]              ack_link;
    logic [N_CELLS-1:0]            claim;
    logic [N_CELLS-1:0]            grant;
    logic [N_CELLS-1:0]            elig;
    logic [N_CELLS-1:0]            isr;
    logic [N_CELLS-1:0][VEC_W-1:0] vec_drive;
    logic [VEC_W-1:0]              vec_or;

    assign ack_link[0] = ack_i;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        irq_chain_cell #(
            .VEC_W  (VEC_W),
            .VECTOR (VEC_BASE + VEC_W'(i))
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_i[i]),
            .ack_in  (ack_link[i]),
            .elig_i  (elig[i]),
            .ack_out (ack_link[i+1]),
            .claim_o (claim[i]),
            .grant_o (grant[i]),
            .vec_o   (vec_drive[i])
        );
    end

    irq_isr_stack #(.N_CELLS(N_CELLS)) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant),
        .eoi_i   (eoi_i),
        .elig_o  (elig),
        .isr_o   (isr)
    );

    // Merge the vector bus; undriven bus reads the idle value.
    always_comb begin
        vec_or = '0;
        for (int i = 0; i < N_CELLS; i++) vec_or = vec_or | vec_drive[i];
        vec_valid_o = |grant;
        vec_o       = vec_valid_o ? vec_or : DEFAULT_VEC;
    end

    // Shared interrupt line.
    assign int_o = |claim;

    AST_ONE_DRIVER:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R5
    AST_IDLE_VECTOR:  assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_o == DEFAULT_VEC)); // R5
    AST_VALID_HAS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> int_o); // R3
    AST_NO_ACK_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> !vec_valid_o); // R4
    AST_GRANT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> (|isr)); // R7
endmodule

// File: tb/tb_irq_chain_ctrl.sv
// Bench tb_irq_chain_ctrl: scoreboard of expected vectors, checked per acknowledge.
module tb_irq_chain_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         ack_i = 1'b0;
    logic         eoi_i = 1'b0;
    logic         int_o;
    logic [7:0]   vec_o;
    logic         vec_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] vec;
        logic       valid;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    irq_chain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .eoi_i(eoi_i),
        .int_o(int_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk); #5;
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        @(negedge clk); req_i = m;
        @(negedge clk); req_i = '0;
    endtask

    task automatic pulse_eoi();
        @(negedge clk); eoi_i = 1'b1;
        @(negedge clk); eoi_i = 1'b0;
    endtask

    // Driver: push expected result, then issue one acknowledge.
    task automatic do_ack(input logic [7:0] v, input logic valid, input string tag,
                          input logic [N-1:0] req_same = '0);
        exp_t e;
        e.vec = v; e.valid = valid; e.tag = tag;
        sb.push_back(e);
        @(negedge clk); ack_i = 1'b1; req_i = req_same;
        @(negedge clk); ack_i = 1'b0; req_i = '0;
    endtask

    // Monitor: compare bus against the scoreboard mid-cycle during acknowledge.
    always @(negedge clk) begin
        #5;
        if (ack_i) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4: actual unexpected ack expected none queued");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " vec"}, 32'(vec_o), 32'(e.vec));
                chk({e.tag, " valid"}, 32'(vec_valid_o), 32'(e.valid));
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 int", 32'(int_o), 0);
        chk("R1 vec", 32'(vec_o), 32'hFF);
        chk("R1 valid", 32'(vec_valid_o), 0);

        do_ack(8'hFF, 1'b0, "R10 idle ack");
        settle(); chk("R10 int after idle ack", 32'(int_o), 0);

        pulse_req(4'b0100);
        #5; chk("R2 int raised", 32'(int_o), 1);
        repeat (3) settle();
        chk("R2 int held", 32'(int_o), 1);

        pulse_req(4'b1010);
        do_ack(8'h21, 1'b1, "R4 lowest index wins");
        settle(); chk("R7 lower masked", 32'(int_o), 0);

        pulse_req(4'b0001);
        #5; chk("R8 preempt int", 32'(int_o), 1);
        do_ack(8'h20, 1'b1, "R8 preempt vector");
        settle(); chk("R7 all masked", 32'(int_o), 0);
        do_ack(8'hFF, 1'b0, "R7 masked pass-through");

        pulse_eoi();
        #5; chk("R9 pop level0 keeps level1", 32'(int_o), 0);
        pulse_eoi();
        #5; chk("R3 int after stack empty", 32'(int_o), 1);
        do_ack(8'h22, 1'b1, "R6 cell2 after pops");
        settle(); chk("R7 cell3 masked by 2", 32'(int_o), 0);
        pulse_eoi();
        #5; chk("R6 cell3 kept", 32'(int_o), 1);
        do_ack(8'h23, 1'b1, "R4 cell3 vector");
        pulse_eoi();
        #5; chk("R9 all retired int low", 32'(int_o), 0);
        pulse_eoi();
        #5; chk("R9 idle eoi no effect", 32'(int_o), 0);
        do_ack(8'hFF, 1'b0, "R5 default after idle eoi");

        pulse_req(4'b0010);
        do_ack(8'h21, 1'b1, "R6 grant with same-cycle req", 4'b0010);
        pulse_eoi();
        #5; chk("R6 clear wins over req", 32'(int_o), 0);

        settle();
        chk("R4 scoreboard drained", 32'(sb.size()), 0);
        done = 1'b1;
        finish_run();
    end
endmodule